// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a host port and an extended-data-out DRAM built as 4M words of 4 bits, with four column strobes that each gate one data bit. A 22-bit host word address is split into an 11-bit row and an 11-bit column. The two halves share one multiplexed address bus. The controller sequences the row strobe, the four column strobes, write enable and output enable. Every timing interval is a parameter counted in clock cycles.

Once a row is open it stays open. A later request to the same row costs only a column cycle. A request to another row first closes the open row, precharges, and then opens the new one. The controller also closes the row in two other cases: when a refresh arbiter raises its grant, and before the row strobe has been low for longer than the page-mode limit.

Reads capture the data at the end of the column-strobe pulse and return it with a one-cycle valid pulse. The data is still valid there because extended-data-out outputs keep driving after the column strobe rises. Writes use the 4-bit mask to choose which column strobes fall. A per-request flag picks between an early write and an output-enable-controlled (late) write.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row strobe is high, all column strobes are high, write enable and output enable are high (inactive), the data drive enable and `rsp_valid` are 0, and `req_ready` is 1 while `ref_grant` is 0.
- R2: The row is `req_addr[21:11]` and the column is `req_addr[10:0]`. The row is on `dram_addr` when the row strobe falls and stays stable for at least the next cycle. The column is on `dram_addr` when a column strobe falls.
- R3: The first column strobe after a row opens falls at least `T_RCD`+1 cycles after the row strobe falls.
- R4: Before the row strobe falls, it has been high for at least `T_RP` cycles.
- R5: While a row is open, a request whose row matches it is served by a column cycle alone. The row strobe does not rise.
- R6: A request to a different row makes the row strobe rise, then precharge, then fall again with the new row.
- R7: A read (`req_write`=0) drives all four column strobes low, with output enable low and write enable high. The data on `dram_dq_in` at the last column-low cycle comes back on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R8: On a write, `dram_cas_n[i]` falls only when `req_mask[i]`=1. Bit i of the mask, of the strobes and of the data bus always belong together.
- R9: An early write (`req_late`=0) lowers write enable at least one cycle before the column strobes fall and drives the data bus from that cycle on. Output enable stays high.
- R10: A late write (`req_late`=1) lowers the column strobes with write enable still high. Write enable falls one cycle later. Output enable stays high.
- R11: While `ref_grant` is 1, `req_ready` is 0. The open row is closed once the minimum row-active time has passed, and the row strobe then stays high.
- R12: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles. An idle open row is closed on its own before this limit.
- R13: No column strobe is low while the row strobe is high. The data drive enable and output enable are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | 1 = late (output-enable-controlled) write |
| req_mask | input | 4 | Per-bit write enable |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Captured read data |
| ref_grant | input | 1 | Refresh arbiter grant; closes the row |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Column strobes, one per data bit, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Write data toward the pads |
| dram_dq_oe | output | 1 | Drive enable for the data pads |
| dram_dq_in | input | 4 | Data from the pads |

## Verification
The assertions take four things for granted. The host holds the address and control fields steady while `req_valid` is high and `req_ready` is low. The timing parameters keep `T_RCD` and `T_CAS` at two cycles or more. The close threshold derived from `T_RAS_MAX` stays above `T_RAS_MIN`. Finally, `ref_grant` is a level that the arbiter keeps high until it sees the row strobe high. The bench changes every input only on the falling clock edge and holds a request until it is accepted. It keeps the default-like timing values and uses a short page limit, so the forced close shows up within a few dozen cycles. Its DRAM model answers only while a column strobe is low.

// File: rtl/edo_pkg.sv
package edo_pkg;

  localparam int ROW_W = 11;
  localparam int COL_W = 11;
  localparam int DQ_W  = 4;
  localparam int ADR_W = ROW_W + COL_W;
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  typedef logic [ROW_W-1:0] row_t;
  typedef logic [COL_W-1:0] col_t;
  typedef logic [PIN_W-1:0] pin_t;
  typedef logic [DQ_W-1:0]  nib_t;
  typedef logic [ADR_W-1:0] adr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CSET,
    ST_CAS,
    ST_OPEN,
    ST_PRE
  } edo_state_e;

  function automatic row_t row_of(input adr_t a);
    return a[ADR_W-1:COL_W];
  endfunction

  function automatic col_t col_of(input adr_t a);
    return a[COL_W-1:0];
  endfunction

  // A lane strobes on every read, and on writes only when its mask bit is set.
  function automatic logic lane_on(input logic wr, input logic mbit);
    return !wr || mbit;
  endfunction

  // Write enable: early write holds it from setup on; late write waits one CAS cycle.
  function automatic logic we_active(input edo_state_e s, input logic wr,
                                     input logic late, input logic first);
    return wr && (((s == ST_CSET) && !late) || ((s == ST_CAS) && (!late || !first)));
  endfunction

endpackage

// File: rtl/edo_step_timer.sv
module edo_step_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int T_RAS_MIN = 8,
  parameter int CLOSE_AT  = 100,
  parameter int W         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_met,
  output logic close_req
);
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (!ras_low)       low_cnt <= '0;
    else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
  end

  assign min_met   = (low_cnt >= W'(T_RAS_MIN - 1));
  assign close_req = (low_cnt >= W'(CLOSE_AT));
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 5,
  parameter int T_CP      = 2,
  parameter int T_CAS     = 2,
  parameter int T_RAS_MIN = 8,
  parameter int T_RAS_MAX = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ADR_W-1:0] req_addr,
  input  logic             req_write,
  input  logic             req_late,
  input  logic [DQ_W-1:0]  req_mask,
  input  logic [DQ_W-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [DQ_W-1:0]  rsp_rdata,
  input  logic             ref_grant,
  output logic             dram_ras_n,
  output logic [DQ_W-1:0]  dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_oe_n,
  output logic [PIN_W-1:0] dram_addr,
  output logic [DQ_W-1:0]  dram_dq_out,
  output logic             dram_dq_oe,
  input  logic [DQ_W-1:0]  dram_dq_in
);
  localparam int STEP_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int STEP_B   = (T_CP > T_CAS) ? T_CP : T_CAS;
  localparam int STEP_MAX = (STEP_A > STEP_B) ? STEP_A : STEP_B;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int RAS_W    = $clog2(T_RAS_MAX + 1);
  localparam int CLOSE_AT = T_RAS_MAX - T_CP - T_CAS - 2;

  edo_state_e         st, st_nxt;
  logic               ld;
  logic [STEP_W-1:0]  ld_val;
  logic               step_done;
  row_t               o_row;
  col_t               c_col;
  logic               c_wr, c_late;
  nib_t               c_mask, c_wdata;
  logic               pend, pend_set;
  logic               in_cas_q;

  // Named internal events, also seen by the bound checker.
  logic take_w, row_hit_w, ras_low, min_met, close_req, cas_first;

  assign row_hit_w = (row_of(req_addr) == o_row);
  assign ras_low   = (st == ST_ACT) || (st == ST_CSET) || (st == ST_CAS) || (st == ST_OPEN);
  assign cas_first = (st == ST_CAS) && !in_cas_q;
  assign take_w    = req_valid && req_ready;

  edo_step_timer #(.W(STEP_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .done     (step_done)
  );

  edo_ras_guard #(.T_RAS_MIN(T_RAS_MIN), .CLOSE_AT(CLOSE_AT), .W(RAS_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_low   (ras_low),
    .min_met   (min_met),
    .close_req (close_req)
  );

  always_comb begin
    st_nxt    = st;
    ld        = 1'b0;
    ld_val    = '0;
    req_ready = 1'b0;
    pend_set  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        req_ready = !ref_grant;
        if (req_valid && !ref_grant) begin
          st_nxt = ST_ACT;
          ld     = 1'b1;
          ld_val = STEP_W'(T_RCD - 1);
        end
      end
      ST_ACT: if (step_done) begin
        st_nxt = ST_CSET;
        ld     = 1'b1;
        ld_val = STEP_W'(T_CP - 1);
      end
      ST_CSET: if (step_done) begin
        st_nxt = ST_CAS;
        ld     = 1'b1;
        ld_val = STEP_W'(T_CAS - 1);
      end
      ST_CAS: if (step_done) st_nxt = ST_OPEN;
      ST_OPEN: begin
        if (ref_grant || close_req) begin
          if (min_met) begin
            st_nxt = ST_PRE;
            ld     = 1'b1;
            ld_val = STEP_W'(T_RP - 1);
          end
        end else begin
          req_ready = row_hit_w || min_met;
          if (req_valid && req_ready) begin
            ld = 1'b1;
            if (row_hit_w) begin
              st_nxt = ST_CSET;
              ld_val = STEP_W'(T_CP - 1);
            end else begin
              st_nxt   = ST_PRE;
              ld_val   = STEP_W'(T_RP - 1);
              pend_set = 1'b1;
            end
          end
        end
      end
      ST_PRE: if (step_done) begin
        if (pend) begin
          st_nxt = ST_ACT;
          ld     = 1'b1;
          ld_val = STEP_W'(T_RCD - 1);
        end else begin
          st_nxt = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      o_row     <= '0;
      c_col     <= '0;
      c_wr      <= 1'b0;
      c_late    <= 1'b0;
      c_mask    <= '0;
      c_wdata   <= '0;
      pend      <= 1'b0;
      in_cas_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st       <= st_nxt;
      in_cas_q <= (st == ST_CAS);
      if (take_w) begin
        o_row   <= row_of(req_addr);
        c_col   <= col_of(req_addr);
        c_wr    <= req_write;
        c_late  <= req_late;
        c_mask  <= req_mask;
        c_wdata <= req_wdata;
      end
      if (pend_set)                            pend <= 1'b1;
      else if ((st == ST_PRE) && step_done)    pend <= 1'b0;
      rsp_valid <= (st == ST_CAS) && step_done && !c_wr;
      if ((st == ST_CAS) && step_done && !c_wr) rsp_rdata <= dram_dq_in;
    end
  end

  // One column strobe per data bit.
  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    assign dram_cas_n[i] = !((st == ST_CAS) && lane_on(c_wr, c_mask[i]));
  end

  assign dram_ras_n  = !ras_low;
  assign dram_addr   = ((st == ST_CSET) || (st == ST_CAS) || (st == ST_OPEN)) ?
                       PIN_W'(c_col) : PIN_W'(o_row);
  assign dram_we_n   = !we_active(st, c_wr, c_late, cas_first);
  assign dram_oe_n   = !((st == ST_CAS) && !c_wr);
  assign dram_dq_oe  = c_wr && (((st == ST_CSET) && !c_late) || (st == ST_CAS));
  assign dram_dq_out = c_wdata;

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk
  import edo_pkg::*;
#(
  parameter int T_RP      = 5,
  parameter int T_RAS_MAX = 12000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_grant,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             dram_ras_n,
  input logic [DQ_W-1:0]  dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic [PIN_W-1:0] dram_addr,
  input logic             dram_dq_oe,
  input logic             take_w,
  input logic             row_hit_w
);
  localparam int CW = $clog2(T_RAS_MAX + 2);

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= CW'(T_RP);
    end else begin
      if (dram_ras_n)         lo_cnt <= '0;
      else if (lo_cnt != '1)  lo_cnt <= lo_cnt + 1'b1;
      if (!dram_ras_n)        hi_cnt <= '0;
      else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |=> $stable(dram_addr));

  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= CW'(T_RP)));

  assert_hit_keeps_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && row_hit_w && !dram_ras_n) |=> !dram_ras_n);

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_we_before_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dram_cas_n != '1) && ($past(dram_cas_n) == '1) && !dram_we_n) |-> !$past(dram_we_n));

  assert_grant_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> !req_ready);

  assert_ras_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (lo_cnt < CW'(T_RAS_MAX)));

  assert_cas_under_ras_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ras_n |-> (dram_cas_n == '1));

  assert_no_contention_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_grant  (ref_grant),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_addr  (dram_addr),
  .dram_dq_oe (dram_dq_oe),
  .take_w     (take_w),
  .row_hit_w  (row_hit_w)
);

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;
  import edo_pkg::*;

  localparam int P_RCD = 2, P_RP = 5, P_CP = 2, P_CAS = 2, P_RMIN = 8, P_RMAX = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_late = 1'b0, ref_grant = 1'b0;
  logic [ADR_W-1:0] req_addr = '0;
  logic [3:0] req_mask = '0, req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0] rsp_rdata, dram_cas_n, dram_dq_out;
  logic [3:0] dram_dq_in = '0;
  logic [PIN_W-1:0] dram_addr;

  edo_page_ctrl #(.T_RCD(P_RCD), .T_RP(P_RP), .T_CP(P_CP), .T_CAS(P_CAS),
                  .T_RAS_MIN(P_RMIN), .T_RAS_MAX(P_RMAX)) u_edo_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_late(req_late),
    .req_mask(req_mask), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ref_grant(ref_grant), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { int row; int col; bit wr; bit late; logic [3:0] mask; } acc_t;
  acc_t       acc_q[$];
  logic [3:0] rd_q[$];
  logic [3:0] shadow[int];
  logic [3:0] mem[int];

  // Monitor and DRAM model, all on the falling edge.
  int ras_falls = 0, since_ras = 0, hi_run = 100, lo_run = 0, max_lo = 0;
  int m_row = 0, m_col = 0;
  bit first_cas = 0, late_pend = 0;
  logic ras_p = 1'b1, we_p = 1'b1;
  logic [3:0] cas_p = 4'hF;

  always @(negedge clk) if (rst_n) begin
    if (!dram_ras_n && ras_p) begin
      ras_falls++;
      m_row = int'(dram_addr);
      chk(hi_run >= P_RP, "R4 precharge cycles", hi_run, P_RP);
      since_ras = 0;
      first_cas = 1;
    end else if (!dram_ras_n) since_ras++;
    if (dram_ras_n) begin hi_run++; lo_run = 0; end
    else begin hi_run = 0; lo_run++; if (lo_run > max_lo) max_lo = lo_run; end

    if (dram_cas_n != 4'hF && cas_p == 4'hF) begin
      m_col = int'(dram_addr);
      if (acc_q.size() == 0) chk(0, "R2 unexpected column cycle", 1, 0);
      else begin
        acc_t a;
        a = acc_q.pop_front();
        chk(m_row == a.row, "R2 row address", m_row, a.row);
        chk(m_col == a.col, "R2 column address", m_col, a.col);
        if (first_cas) chk(since_ras >= P_RCD + 1, "R3 RAS to CAS", since_ras, P_RCD + 1);
        if (a.wr) begin
          chk(dram_cas_n == ~a.mask, "R8 masked strobes", dram_cas_n, ~a.mask);
          chk(dram_oe_n == 1'b1, "R9 R10 OE high on write", dram_oe_n, 1);
          if (!a.late)
            chk(!dram_we_n && !we_p && dram_dq_oe, "R9 early WE and drive",
                {we_p, dram_we_n, dram_dq_oe}, 1);
          else begin
            chk(dram_we_n == 1'b1, "R10 WE high at CAS fall", dram_we_n, 1);
            late_pend = 1;
          end
        end else
          chk(dram_cas_n == 4'h0 && !dram_oe_n && dram_we_n, "R7 read strobes",
              {dram_cas_n, dram_oe_n, dram_we_n}, 1);
      end
      first_cas = 0;
    end else if (late_pend) begin
      chk(!dram_we_n, "R10 WE low one cycle later", dram_we_n, 0);
      late_pend = 0;
    end

    if (!dram_ras_n && dram_cas_n != 4'hF) begin
      int key;
      logic [3:0] v;
      key = m_row * 2048 + m_col;
      v = mem.exists(key) ? mem[key] : 4'h0;
      if (!dram_we_n && dram_dq_oe) begin
        for (int i = 0; i < 4; i++) if (!dram_cas_n[i]) v[i] = dram_dq_out[i];
        mem[key] = v;
      end else dram_dq_in = v;
    end

    if (rsp_valid) begin
      if (rd_q.size() == 0) chk(0, "R7 unexpected read data", 1, 0);
      else begin
        logic [3:0] e;
        e = rd_q.pop_front();
        chk(rsp_rdata == e, "R7 read data", rsp_rdata, e);
      end
    end
    ras_p = dram_ras_n;
    cas_p = dram_cas_n;
    we_p  = dram_we_n;
  end

  // Driver: pushes expectations into the scoreboard queues at acceptance.
  task automatic issue(input logic [21:0] a, input bit wr, input logic [3:0] m,
                       input logic [3:0] d, input bit late);
    acc_t e;
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_mask = m;
    req_wdata = d; req_late = late;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    k = int'(a);
    e.row = k / 2048; e.col = k % 2048; e.wr = wr; e.late = late; e.mask = m;
    acc_q.push_back(e);
    if (wr) begin
      logic [3:0] o;
      o = shadow.exists(k) ? shadow[k] : 4'h0;
      shadow[k] = (o & ~m) | (d & m);
    end else rd_q.push_back(shadow.exists(k) ? shadow[k] : 4'h0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (acc_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_all();
    int f0;
    logic [21:0] a0, b0, c0;
    a0 = {11'd3, 11'd5};
    b0 = {11'd9, 11'd100};
    c0 = {11'd700, 11'd2047};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dram_ras_n == 1'b1 && dram_cas_n == 4'hF, "R1 strobes idle", {dram_ras_n, dram_cas_n}, 5'h1F);
    chk(dram_we_n && dram_oe_n && !dram_dq_oe, "R1 WE OE drive idle", {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b110);
    chk(!rsp_valid && req_ready, "R1 handshake idle", {rsp_valid, req_ready}, 2'b01);

    // Same-row traffic: one row opening only (R5).
    f0 = ras_falls;
    issue(a0, 1, 4'hF, 4'hA, 0);
    issue(a0, 0, 4'h0, 4'h0, 0);
    issue(a0 + 1, 1, 4'b0101, 4'hF, 1);
    issue(a0 + 1, 0, 4'h0, 4'h0, 0);
    settle();
    chk(ras_falls == f0 + 1, "R5 row kept open for hits", ras_falls - f0, 1);

    // Row miss reopens (R6), partial masks, early and late (R8 R9 R10).
    f0 = ras_falls;
    issue(b0, 0, 4'h0, 4'h0, 0);
    issue(b0, 1, 4'hF, 4'hA, 0);
    issue(b0, 1, 4'b0011, 4'h5, 0);
    issue(b0, 0, 4'h0, 4'h0, 0);
    issue(b0, 1, 4'b1000, 4'h0, 1);
    issue(b0, 0, 4'h0, 4'h0, 0);
    issue(a0, 0, 4'h0, 4'h0, 0);
    issue(c0, 1, 4'b0110, 4'hF, 1);
    issue(c0, 0, 4'h0, 4'h0, 0);
    settle();
    chk(ras_falls == f0 + 3, "R6 row misses reopen", ras_falls - f0, 3);

    // Refresh grant closes the row and blocks the host (R11).
    issue(a0, 0, 4'h0, 4'h0, 0);
    settle();
    @(negedge clk);
    ref_grant = 1'b1;
    #1;
    chk(!req_ready, "R11 ready low under grant", req_ready, 0);
    repeat (20) @(negedge clk);
    #1;
    chk(dram_ras_n == 1'b1 && dram_cas_n == 4'hF, "R11 row closed under grant", {dram_ras_n, dram_cas_n}, 5'h1F);
    chk(!req_ready, "R11 ready still low", req_ready, 0);
    @(negedge clk);
    ref_grant = 1'b0;

    // Long page burst and idle row: forced close (R12).
    max_lo = 0;
    for (int i = 0; i < 25; i++) issue(a0 + 22'(i), 0, 4'h0, 4'h0, 0);
    settle();
    repeat (P_RMAX + 20) @(negedge clk);
    #1;
    chk(dram_ras_n == 1'b1, "R12 idle row closed by itself", dram_ras_n, 1);
    chk(max_lo <= P_RMAX, "R12 RAS low run bounded", max_lo, P_RMAX);
    chk(max_lo >= P_RMAX - 5, "R12 limit reached in burst", max_lo, P_RMAX - 5);
    chk(rd_q.size() == 0 && acc_q.size() == 0, "R7 all accesses answered",
        rd_q.size() + acc_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule